// File: doc/BRIEF.md
# Lower-part OR approximate adder

This block adds two unsigned N-bit operands approximately, trading exactness in the low-order bits for a shorter and cheaper carry path. The lowest L result bits carry no carry chain at all: each one is the OR of the two operand bits at that position. The remaining N-L bits come from an exact parallel-prefix adder. That adder gets its carry-in from a single AND gate looking at the two operand bits just below the split. The result is N+1 bits wide, and its top bit is the carry-out of the upper adder.

The block is purely combinational. It has no clock, no reset and no handshake. A result follows its operands within the same cycle and is meant to be registered by the surrounding datapath. L picks the split between accuracy and cost. L = 0 gives an exact adder. L = N gives a pure OR of the operands with a guessed top bit. Every error stays within a window set by L, so the error rate is high but the relative error stays small. It suits error-tolerant paths such as filters and accumulators on media data.

Top module: `lor_adder`

## Requirements
- R1: For every bit position i < L, result bit i equals a_i[i] | b_i[i].
- R2: For 0 < L < N, result bits N..L equal a_i[N-1:L] + b_i[N-1:L] + g, where g = a_i[L-1] & b_i[L-1]. The sum is N-L+1 bits wide and its top bit is result bit N.
- R3: For L > 0, the signed difference between the result and the exact sum a_i + b_i never exceeds 2^(L-1) in magnitude. This lies within the 2^L bound.
- R4: Whenever (a_i & b_i) has no set bit below position L, the result equals the exact sum a_i + b_i.
- R5: With L = 0 the result is the exact (N+1)-bit sum a_i + b_i.
- R6: With L = N the result is {a_i[N-1] & b_i[N-1], a_i | b_i}.
- R7: The result is combinational. A change of operands shows at sum_o without any clock edge, and zero operands give a zero result.
- R8: For L > 0 the result is strictly above the exact sum when g = 1, and at or below it when g = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| a_i | input | N | First unsigned operand |
| b_i | input | N | Second unsigned operand |
| sum_o | output | N+1 | Approximate sum; bit N is the upper carry-out |

## Verification
The bench builds three copies with N = 8: L = 3 as the mixed case, L = 0 for the exact case and L = 8 for the all-OR case. All three are driven with every one of the 65536 operand pairs. At this width every pattern of the guessed carry and every lower-field overlap can be reached. This includes the worst-case error at the 2^(L-1) limit and the all-ones carry-out, checked against arithmetic references. Both ends of the L range also get a full sweep at this width.

// File: rtl/lor_adder_pkg.sv
package lor_adder_pkg;

  // Number of prefix-combine levels needed to span w bit positions.
  function automatic int prefix_depth(input int w);
    int d;
    d = 0;
    while ((1 << d) < w) d++;
    return d;
  endfunction

endpackage

// File: rtl/lor_or_lower.sv
// Carry-free low field: each result bit is the OR of the operand bits.
module lor_or_lower #(
  parameter int L = 4
) (
  input  logic [L-1:0] a_i,
  input  logic [L-1:0] b_i,
  output logic [L-1:0] y_o
);
  for (genvar i = 0; i < L; i++) begin : g_bit
    assign y_o[i] = a_i[i] | b_i[i];
  end
endmodule

// File: rtl/lor_carry_guess.sv
// Single-gate estimate of the carry leaving the low field.
module lor_carry_guess (
  input  logic a_top_i,
  input  logic b_top_i,
  output logic c_o
);
  assign c_o = a_top_i & b_top_i;
endmodule

// File: rtl/lor_prefix_upper.sv
// Exact W-bit parallel-prefix (log-depth) adder with carry-in.
module lor_prefix_upper
  import lor_adder_pkg::*;
#(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cin_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  localparam int S = prefix_depth(W);

  logic [W-1:0] prop;
  logic [W-1:0] gen [S+1];
  logic [W-1:0] grp [S+1];
  logic [W:0]   carry;

  assign prop = a_i ^ b_i;

  // Level 0: fold the carry-in into the generate term of bit 0.
  for (genvar i = 0; i < W; i++) begin : g_lvl0
    if (i == 0) begin : g_first
      assign gen[0][i] = (a_i[i] & b_i[i]) | (prop[i] & cin_i);
    end else begin : g_rest
      assign gen[0][i] = a_i[i] & b_i[i];
    end
    assign grp[0][i] = prop[i];
  end

  // Combine levels at doubling span.
  for (genvar k = 1; k <= S; k++) begin : g_lvl
    localparam int D = 1 << (k - 1);
    for (genvar i = 0; i < W; i++) begin : g_col
      if (i >= D) begin : g_merge
        assign gen[k][i] = gen[k-1][i] | (grp[k-1][i] & gen[k-1][i-D]);
        assign grp[k][i] = grp[k-1][i] & grp[k-1][i-D];
      end else begin : g_pass
        assign gen[k][i] = gen[k-1][i];
        assign grp[k][i] = grp[k-1][i];
      end
    end
  end

  assign carry[0]   = cin_i;
  assign carry[W:1] = gen[S];
  assign sum_o      = prop ^ carry[W-1:0];
  assign cout_o     = carry[W];
endmodule

// File: rtl/lor_adder.sv
// Lower-part OR approximate adder, L <= N.
module lor_adder #(
  parameter int N = 16,
  parameter int L = 6
) (
  input  logic [N-1:0] a_i,
  input  logic [N-1:0] b_i,
  output logic [N:0]   sum_o
);
  localparam int W = N - L;

  if (L == 0) begin : g_exact
    logic [N-1:0] up_sum;
    logic         up_co;
    lor_prefix_upper #(.W(N)) u_upper (
      .a_i(a_i), .b_i(b_i), .cin_i(1'b0), .sum_o(up_sum), .cout_o(up_co)
    );
    assign sum_o = {up_co, up_sum};
  end else if (W == 0) begin : g_or_only
    logic [L-1:0] lo;
    logic         guess;
    lor_or_lower #(.L(L)) u_lower (.a_i(a_i), .b_i(b_i), .y_o(lo));
    lor_carry_guess u_guess (.a_top_i(a_i[L-1]), .b_top_i(b_i[L-1]), .c_o(guess));
    assign sum_o = {guess, lo};
  end else begin : g_split
    logic [L-1:0] lo;
    logic         guess;
    logic [W-1:0] up_sum;
    logic         up_co;
    lor_or_lower #(.L(L)) u_lower (.a_i(a_i[L-1:0]), .b_i(b_i[L-1:0]), .y_o(lo));
    lor_carry_guess u_guess (.a_top_i(a_i[L-1]), .b_top_i(b_i[L-1]), .c_o(guess));
    lor_prefix_upper #(.W(W)) u_upper (
      .a_i(a_i[N-1:L]), .b_i(b_i[N-1:L]), .cin_i(guess),
      .sum_o(up_sum), .cout_o(up_co)
    );
    assign sum_o = {up_co, up_sum, lo};
  end
endmodule

// File: rtl/lor_adder_chk.sv
module lor_adder_chk #(
  parameter int N = 16,
  parameter int L = 6
) (
  input logic [N-1:0] a_i,
  input logic [N-1:0] b_i,
  input logic [N:0]   sum_o
);
  localparam int BOUND_I = (L == 0) ? 0 : (1 << (L - 1));
  localparam logic signed [N+1:0] ERR_HI = (N+2)'(BOUND_I);
  localparam logic [N-1:0] LMASK = N'((64'(1) << L) - 64'(1));

  logic [N:0]          exact;
  logic signed [N+1:0] err;

  always_comb begin
    exact = {1'b0, a_i} + {1'b0, b_i};
    err   = $signed({1'b0, sum_o}) - $signed({1'b0, exact});
    p_err_window_r3: assert (err <= ERR_HI && err >= -ERR_HI);
    if ((a_i & b_i & LMASK) == '0) begin
      p_exact_no_overlap_r4: assert (sum_o == exact);
    end
  end

  if (L > 0) begin : g_low
    always_comb begin
      p_lower_or_r1: assert (sum_o[L-1:0] == (a_i[L-1:0] | b_i[L-1:0]));
      if (a_i[L-1] & b_i[L-1]) begin
        p_over_when_guess_r8: assert (err > 0);
      end else begin
        p_under_no_guess_r8: assert (err <= 0);
      end
    end
  end
endmodule

bind lor_adder lor_adder_chk #(.N(N), .L(L)) u_chk (
  .a_i(a_i), .b_i(b_i), .sum_o(sum_o)
);

// File: tb/lor_adder_tb.sv
module lor_adder_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N = 8;
  localparam int LM = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] a = '0;
  logic [N-1:0] b = '0;
  logic [N:0] s_mid, s_exact, s_full;
  int n_checks = 0;
  int n_err = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lor_adder #(.N(N), .L(LM)) u_dut       (.a_i(a), .b_i(b), .sum_o(s_mid));
  lor_adder #(.N(N), .L(0))  u_dut_exact (.a_i(a), .b_i(b), .sum_o(s_exact));
  lor_adder #(.N(N), .L(N))  u_dut_full  (.a_i(a), .b_i(b), .sum_o(s_full));

  task automatic chk(input string tag, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s a=%0d b=%0d actual %0d expected %0d", tag, a, b, act, exp);
    end
  endtask

  task automatic check_all();
    int ai, bi, ex, sm, e, g, lo, hi;
    ai = int'(a);
    bi = int'(b);
    ex = ai + bi;
    sm = int'(s_mid);
    e  = sm - ex;
    g  = int'(a[LM-1] & b[LM-1]);
    lo = (ai | bi) & ((1 << LM) - 1);
    hi = (ai >> LM) + (bi >> LM) + g;
    chk("R1", sm & ((1 << LM) - 1), lo);
    chk("R2", sm >> LM, hi);
    chk("R3", (e > 4 || e < -4) ? e : 0, 0);
    if (((ai & bi) & ((1 << LM) - 1)) == 0) chk("R4", sm, ex);
    chk("R8", (e > 0) ? 1 : 0, g);
    chk("R5", int'(s_exact), ex);
    chk("R6", int'(s_full), (int'(a[N-1] & b[N-1]) << N) | (ai | bi));
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R7", int'(s_mid), 0);
    chk("R7", int'(s_exact), 0);
    chk("R7", int'(s_full), 0);
    rst_n = 1'b1;
    for (int i = 0; i < 65536; i++) begin
      @(posedge clk);
      a = i[7:0];
      b = i[15:8];
      @(negedge clk);
      check_all();
    end
    // R7: change operands mid-cycle, observe before the next edge
    @(negedge clk);
    a = 8'hFF;
    b = 8'hFF;
    #1;
    chk("R7", int'(s_mid), 9'h1FF);
    chk("R7", int'(s_exact), 9'h1FE);
    a = 8'h05;
    b = 8'h02;
    #1;
    chk("R7", int'(s_mid), 7);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_err);
      $finish;
    end
  end
endmodule